// File: doc/BRIEF.md
# Modem Status Change Detector

This block holds the modem status register of a 16550-style serial port. It watches four modem input lines (clear-to-send, data-set-ready, ring indicator and carrier detect), passes them through a two-flop synchroniser and keeps their present levels in the upper nibble of an 8-bit status value. Each level has a sticky change flag in the lower nibble. A flag stays set until the host reads the register, and the interrupt request stays raised while the flags are set and the enable is high.

In loopback mode the four modem control outputs drive the level bits in place of the pins. A read strobe returns the register as it stands and clears the change flags on the same clock edge. A change that lands in the same cycle as the read is not lost: it is latched as a fresh flag after the clear. The ring flag differs from the other three. It is raised only when the ring line falls from asserted to deasserted.

Top module: `modem_status_tracker`

## Requirements
- R1: Bits 7:4 of `msr_q` hold the levels DCD (bit 7), RI (bit 6), DSR (bit 5) and CTS (bit 4). A pin change shows there after three rising edges: two synchroniser stages and the level register.
- R2: Change flags in bits 3:0 sit under their levels: CTS in bit 0, DSR in bit 1, DCD in bit 3. Either edge of CTS, DSR or DCD sets its flag. The flags accumulate until a read.
- R3: While `rd_stb` is high, `msr_q` shows the value before the clear. At the next edge bits 3:0 clear, unless R7 applies.
- R4: The ring flag (bit 2) sets only when RI goes from 1 to 0. A rising RI leaves it unchanged.
- R5: When `loop_en` is high, `mctl` bit 1 drives CTS (bit 4), bit 0 drives DSR (bit 5), bit 2 drives RI (bit 6) and bit 3 drives DCD (bit 7). These take effect one edge later, with no synchroniser delay.
- R6: After synchronous reset `msr_q` reads 0xB0 (DCD, DSR and CTS asserted, RI low, no flags), and `irq` is low.
- R7: A level change on the same edge as a read sets its flag after the clear.
- R8: `irq` is high exactly when `irq_en` is high and any bit of `msr_q[3:0]` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_cts | input | 1 | Clear-to-send line, asynchronous, 1 = asserted |
| pin_dsr | input | 1 | Data-set-ready line, asynchronous, 1 = asserted |
| pin_ri | input | 1 | Ring indicator line, asynchronous, 1 = asserted |
| pin_dcd | input | 1 | Carrier detect line, asynchronous, 1 = asserted |
| loop_en | input | 1 | Selects modem control outputs as the level source |
| mctl | input | 4 | Modem control outputs: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2 |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Host read of the register, one cycle per read |
| msr_q | output | 8 | Status register: levels 7:4, change flags 3:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a level change that lands on the same edge as the host read, where the clear and the new flag compete. Loopback drives the levels with one-edge latency, so the bench can place the `mctl` change exactly on the read cycle. With the synchronised pins that alignment would depend on counting three edges. The ring line's one-sided flag is tested in both directions: through loopback with flags already set and with them clear, and through the pins with the synchroniser delay.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NLINES = 4;
  // Level / flag bit order inside a nibble
  localparam int B_CTS = 0;
  localparam int B_DSR = 1;
  localparam int B_RI  = 2;
  localparam int B_DCD = 3;
  // DCD, DSR, CTS asserted after reset; RI low
  localparam logic [NLINES-1:0] RST_LEVELS = 4'b1011;
  typedef logic [NLINES-1:0] nib_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= RST_VAL;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/msr_src_mux.sv
module msr_src_mux
  import msr_pkg::*;
(
  input  nib_t       pins_sync,
  input  logic       loop_en,
  input  logic [3:0] mctl,
  output nib_t       src
);
  nib_t loop_lvl;

  always_comb begin
    loop_lvl        = '0;
    loop_lvl[B_CTS] = mctl[1];
    loop_lvl[B_DSR] = mctl[0];
    loop_lvl[B_RI]  = mctl[2];
    loop_lvl[B_DCD] = mctl[3];
    src = loop_en ? loop_lvl : pins_sync;
  end
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
  parameter int W      = 4,
  parameter int FALL_BIT = 2,
  parameter logic [W-1:0] RST_LVL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         clr,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] flg_q
);
  logic [W-1:0] chg;

  always_comb begin
    chg = lvl_q ^ src;
    // falling-edge-only line
    chg[FALL_BIT] = lvl_q[FALL_BIT] & ~src[FALL_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= RST_LVL;
      flg_q <= '0;
    end else begin
      lvl_q <= src;
      flg_q <= (clr ? '0 : flg_q) | chg;
    end
  end
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_cts,
  input  logic       pin_dsr,
  input  logic       pin_ri,
  input  logic       pin_dcd,
  input  logic       loop_en,
  input  logic [3:0] mctl,
  input  logic       irq_en,
  input  logic       rd_stb,
  output logic [7:0] msr_q,
  output logic       irq
);
  nib_t pins_raw, pins_sync, src_lvl, lvl_q, flg_q;

  always_comb begin
    pins_raw        = '0;
    pins_raw[B_CTS] = pin_cts;
    pins_raw[B_DSR] = pin_dsr;
    pins_raw[B_RI]  = pin_ri;
    pins_raw[B_DCD] = pin_dcd;
  end

  msr_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(RST_LEVELS)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_sync)
  );

  msr_src_mux u_mux (
    .pins_sync(pins_sync), .loop_en(loop_en), .mctl(mctl), .src(src_lvl)
  );

  msr_delta #(.W(NLINES), .FALL_BIT(B_RI), .RST_LVL(RST_LEVELS)) u_delta (
    .clk(clk), .rst(rst), .src(src_lvl), .clr(rd_stb),
    .lvl_q(lvl_q), .flg_q(flg_q)
  );

  assign msr_q = {lvl_q, flg_q};
  assign irq   = irq_en & (|flg_q);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] src_lvl,
  input logic       loop_en,
  input logic [3:0] mctl,
  input logic       irq_en,
  input logic       rd_stb,
  input logic [7:0] msr_q,
  input logic       irq
);
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> msr_q[7:4] == $past(src_lvl)); // R1

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> (msr_q[3:0] & $past(msr_q[3:0])) == $past(msr_q[3:0])); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && src_lvl == msr_q[7:4]) |=> msr_q[3:0] == 4'h0); // R3

  AST_RI_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && msr_q[6] && !$past(msr_q[6]) && !$past(msr_q[2])) |-> !msr_q[2]); // R4

  AST_LOOP_CTS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loop_en)) |-> msr_q[4] == $past(mctl[1])); // R5

  AST_READ_RACE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && src_lvl[0] != msr_q[4]) |=> msr_q[0]); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (!irq_en || msr_q[3:0] == 4'h0) |-> !irq); // R8
endmodule

bind modem_status_tracker msr_checker u_chk (
  .clk(clk), .rst(rst), .src_lvl(src_lvl), .loop_en(loop_en), .mctl(mctl),
  .irq_en(irq_en), .rd_stb(rd_stb), .msr_q(msr_q), .irq(irq)
);

// File: tb/sim_modem_status_tracker.sv
`timescale 1ns/1ps
module sim_modem_status_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {mctl[3:0], rd, expected msr_q[7:0]}; loopback, starting from 0x00
  localparam logic [12:0] VEC [NVEC] = '{
    {4'b0010, 1'b0, 8'h11},  // R5 RTS->CTS, R2 flag
    {4'b0011, 1'b0, 8'h33},  // R5 DTR->DSR, R2 accumulate
    {4'b0111, 1'b0, 8'h73},  // R4 RI rise, no flag
    {4'b0011, 1'b0, 8'h37},  // R4 RI fall sets flag
    {4'b0011, 1'b1, 8'h30},  // R3 read clears
    {4'b1011, 1'b0, 8'hB8},  // R5 OUT2->DCD
    {4'b1001, 1'b1, 8'hA1},  // R7 change during read kept
    {4'b1001, 1'b1, 8'hA0},  // R3
    {4'b1101, 1'b0, 8'hE0},  // R4 rise from clean
    {4'b1001, 1'b0, 8'hA4}   // R4 fall
  };

  logic clk = 1'b0, rst = 1'b1;
  logic pin_cts = 1'b1, pin_dsr = 1'b1, pin_ri = 1'b0, pin_dcd = 1'b1;
  logic loop_en = 1'b0, irq_en = 1'b0, rd_stb = 1'b0;
  logic [3:0] mctl = 4'h0;
  logic [7:0] msr_q;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_tracker u0 (
    .clk(clk), .rst(rst), .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_ri(pin_ri),
    .pin_dcd(pin_dcd), .loop_en(loop_en), .mctl(mctl), .irq_en(irq_en),
    .rd_stb(rd_stb), .msr_q(msr_q), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R6 reset value", msr_q, 8'hB0);
    chk("R6 reset irq", {7'd0, irq}, 8'h00);

    // enter loopback with all controls low, then clear
    loop_en = 1'b1; irq_en = 1'b1;
    tick(1);
    chk("R5 loopback entry", msr_q, 8'h0B);
    rd_stb = 1'b1;
    tick(1);
    rd_stb = 1'b0;
    chk("R3 clear after entry", msr_q, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      mctl = VEC[i][12:9];
      rd_stb = VEC[i][8];
      tick(1);
      chk($sformatf("R2/R3/R4/R5/R7 vector %0d", i), msr_q, VEC[i][7:0]);
      chk($sformatf("R8 irq vector %0d", i), {7'd0, irq}, {7'd0, |VEC[i][3:0]});
    end
    rd_stb = 1'b0;

    // R8: enable low masks a set flag
    irq_en = 1'b0;
    #1 chk("R8 irq masked", {7'd0, irq}, 8'h00);

    // back to pins (1,1,1,0): levels become 1011 with flags
    loop_en = 1'b0; mctl = 4'h0;
    tick(2);
    rd_stb = 1'b1;
    tick(1);
    rd_stb = 1'b0;
    chk("R1 pin levels", msr_q, 8'hB0);

    // R1 latency: drop CTS
    pin_cts = 1'b0;
    tick(2);
    chk("R1 not yet after two edges", msr_q, 8'hB0);
    tick(1);
    chk("R1 CTS after three edges", msr_q, 8'hA1);

    // R3: read shows pre-clear value while strobe high
    rd_stb = 1'b1;
    #1 chk("R3 value during read", msr_q, 8'hA1);
    tick(1);
    rd_stb = 1'b0;
    chk("R3 cleared after read", msr_q, 8'hA0);

    // R4 through pins
    pin_ri = 1'b1;
    tick(4);
    chk("R4 pin RI rise no flag", msr_q, 8'hE0);
    pin_ri = 1'b0;
    tick(4);
    chk("R4 pin RI fall flag", msr_q, 8'hA4);

    // R2 DSR and DCD via pins accumulate
    pin_dsr = 1'b0; pin_dcd = 1'b0;
    tick(4);
    chk("R2 pin DSR/DCD flags", msr_q, 8'h0E);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule